// File: doc/BRIEF.md
# SDRAM Read Burst Capture Pipeline

This block is the controller half of an SDRAM read path. Read requests carrying a bank, a column and a tag arrive through a valid/ready handshake. The block turns each accepted request into a READ on a registered command bus. It puts a NOP there on every other cycle. Every issued READ is followed through a shift register whose timing depends on the CAS latency currently in force. On each cycle where the memory drives read data, the block captures the bus and presents it with a strobe, the request tag and the word's position inside its burst.

Reads may be issued on any cycle, including the cycle right after another read, to any bank. A read that lands while an earlier burst is still running cuts that burst short. Words of the old burst scheduled at or after the new burst's first data cycle are discarded. Words scheduled before it are still delivered. Reads spaced exactly one burst length apart therefore produce a continuous data stream.

The CAS latency setting is taken from a configuration input. It is copied into the block only while no read is in flight. While the two values differ, the handshake holds requests off.

Top module: `sdram_rd_pipe`

## Requirements
- R1: A request accepted at clock edge k (req_valid and req_ready both high) puts cmd_read=1 with that request's bank and column on the command outputs for the cycle after edge k. In every cycle with no accepted request, cmd_read is 0 (NOP).
- R2: The data mask output dqm is 0 in every cycle.
- R3: For a READ accepted at edge k with latency L (1, 2 or 3), the first word is captured from dq_in at edge k+1+L. In the cycle after that edge, rd_valid=1, rd_beat=0 and rd_tag equals the request tag.
- R4: A burst yields four words on consecutive capture edges. rd_beat counts 0,1,2,3, and rd_data carries the word the memory returns for column c, c+1, c+2, c+3 (modulo 512) in that order.
- R5: A READ accepted four cycles after the previous one has its first word on the cycle directly after the previous burst's last word, with no idle cycle, for every latency.
- R6: When a READ is accepted while a burst is in flight, old-burst words whose capture edge is at or after the new burst's first capture edge are dropped. Older words before that edge are still delivered.
- R7: cfg_cl values 1 to 3 select that latency, and 0 selects 1. The setting is loaded only while no read is in flight. req_ready is 0 whenever the selected value differs from the loaded one.
- R8: After reset, cmd_read=0, rd_valid=0, and the loaded latency is 3, so req_ready=1 while cfg_cl=3.
- R9: rd_valid is 0 in every cycle that carries no word scheduled by R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | $clog2(MAX_CL+1) | Requested CAS latency (0 means 1) |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Bank of the request |
| req_col | input | COL_W | Start column of the request |
| req_tag | input | TAG_W | Tag returned with the data |
| cmd_read | output | 1 | 1 = READ, 0 = NOP on the command bus |
| cmd_bank | output | BANK_W | Bank of the issued READ |
| cmd_col | output | COL_W | Column of the issued READ |
| dqm | output | DATA_W/8 | Data mask, held low |
| dq_in | input | DATA_W | Read data bus from the memory |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |
| rd_tag | output | TAG_W | Tag of the burst the word belongs to |
| rd_beat | output | max(1,$clog2(BURST_LEN)) | Word index inside the burst |

## Verification
The hardest situation to reach is a truncation. Here two or three bursts overlap in the tracker, and old words must be kept in front of the new burst's first word but dropped behind it. The boundary moves with the latency. The stimulus issues reads at spacings of one, two, three, four and five cycles under each of the three latencies. A responder schedules the memory data from the command bus alone, and the scoreboard trims its expected queue whenever a newer read starts earlier than the queued words. A latency change is also attempted while reads are still draining, to show the handshake holds off until the tracker is empty.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

   typedef enum logic {
      CMD_NOP  = 1'b0,
      CMD_READ = 1'b1
   } rd_cmd_e;

   function automatic int beat_width(input int burst_len);
      return (burst_len > 1) ? $clog2(burst_len) : 1;
   endfunction

endpackage

// File: rtl/rd_cmd_issue.sv
module rd_cmd_issue
   import sdram_rd_pkg::*;
#(
   parameter int BANK_W   = 2,
   parameter int COL_W    = 9,
   parameter int MAX_CL   = 3,
   parameter int RESET_CL = 3,
   parameter int CL_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CL_W-1:0]   cfg_cl,
   input  logic              req_valid,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic              pipe_busy,
   output logic              req_ready,
   output logic              issue,
   output logic [CL_W-1:0]   cl_lat,
   output logic              cmd_read,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [COL_W-1:0]  cmd_col
);

   rd_cmd_e           cmd_q;
   logic [CL_W-1:0]   cl_sel;

   function automatic logic [CL_W-1:0] clamp_cl(input logic [CL_W-1:0] v);
      if (v == '0)
         return CL_W'(1);
      if (int'(v) > MAX_CL)
         return CL_W'(MAX_CL);
      return v;
   endfunction

   assign cl_sel    = clamp_cl(cfg_cl);
   assign req_ready = (cl_sel == cl_lat);
   assign issue     = req_valid && req_ready;
   assign cmd_read  = (cmd_q == CMD_READ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cl_lat   <= CL_W'(RESET_CL);
         cmd_q    <= CMD_NOP;
         cmd_bank <= '0;
         cmd_col  <= '0;
      end else begin
         if (!pipe_busy)
            cl_lat <= cl_sel;
         cmd_q <= issue ? CMD_READ : CMD_NOP;
         if (issue) begin
            cmd_bank <= req_bank;
            cmd_col  <= req_col;
         end
      end
   end

endmodule

// File: rtl/rd_track_pipe.sv
module rd_track_pipe #(
   parameter int TAG_W     = 4,
   parameter int BEAT_W    = 2,
   parameter int BURST_LEN = 4,
   parameter int MAX_CL    = 3,
   parameter int CL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic [CL_W-1:0]   cl_lat,
   output logic              head_valid,
   output logic [BEAT_W-1:0] head_beat,
   output logic [TAG_W-1:0]  head_tag,
   output logic              busy
);

   localparam int DEPTH = MAX_CL + BURST_LEN;

   // slot i holds the word to capture i+1 edges from now; slot DEPTH is a constant empty pad
   logic              v_q [DEPTH+1];
   logic [BEAT_W-1:0] b_q [DEPTH+1];
   logic [TAG_W-1:0]  t_q [DEPTH+1];
   logic              v_n [DEPTH];
   logic [BEAT_W-1:0] b_n [DEPTH];
   logic [TAG_W-1:0]  t_n [DEPTH];
   logic [DEPTH-1:0]  v_vec;

   always_comb begin
      int off;
      for (int i = 0; i < DEPTH; i++) begin
         off = i - int'(cl_lat);
         if (issue && off >= 0) begin
            // new burst owns every slot from its first word onward
            v_n[i] = (off < BURST_LEN);
            b_n[i] = BEAT_W'(off);
            t_n[i] = issue_tag;
         end else begin
            v_n[i] = v_q[i+1];
            b_n[i] = b_q[i+1];
            t_n[i] = t_q[i+1];
         end
      end
   end

   always_ff @(posedge clk) begin
      v_q[DEPTH] <= 1'b0;
      b_q[DEPTH] <= '0;
      t_q[DEPTH] <= '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n) begin
            v_q[i] <= 1'b0;
            b_q[i] <= '0;
            t_q[i] <= '0;
         end else begin
            v_q[i] <= v_n[i];
            b_q[i] <= b_n[i];
            t_q[i] <= t_n[i];
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_vec
         assign v_vec[g] = v_q[g];
      end
   endgenerate

   assign busy       = |v_vec;
   assign head_valid = v_q[0];
   assign head_beat  = b_q[0];
   assign head_tag   = t_q[0];

endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 4,
   parameter int BEAT_W    = 2,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic [BEAT_W-1:0] head_beat,
   input  logic [TAG_W-1:0]  head_tag,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [BEAT_W-1:0] rd_beat
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_tag   <= '0;
         rd_beat  <= '0;
      end else begin
         rd_valid <= head_valid;
         if (head_valid) begin
            rd_tag  <= head_tag;
            rd_beat <= head_beat;
         end
      end
   end

   generate
      if (HOLD_DATA) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)
               rd_data <= '0;
            else if (head_valid)
               rd_data <= dq_in;
         end
      end else begin : g_free
         always_ff @(posedge clk) begin
            rd_data <= dq_in;
         end
      end
   endgenerate

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
   import sdram_rd_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int COL_W     = 9,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 4,
   parameter int BURST_LEN = 4,
   parameter int MAX_CL    = 3,
   parameter int RESET_CL  = 3,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [$clog2(MAX_CL+1)-1:0]          cfg_cl,
   input  logic                                 req_valid,
   output logic                                 req_ready,
   input  logic [BANK_W-1:0]                    req_bank,
   input  logic [COL_W-1:0]                     req_col,
   input  logic [TAG_W-1:0]                     req_tag,
   output logic                                 cmd_read,
   output logic [BANK_W-1:0]                    cmd_bank,
   output logic [COL_W-1:0]                     cmd_col,
   output logic [DATA_W/8-1:0]                  dqm,
   input  logic [DATA_W-1:0]                    dq_in,
   output logic                                 rd_valid,
   output logic [DATA_W-1:0]                    rd_data,
   output logic [TAG_W-1:0]                     rd_tag,
   output logic [beat_width(BURST_LEN)-1:0]     rd_beat
);

   localparam int CL_W   = $clog2(MAX_CL + 1);
   localparam int BEAT_W = beat_width(BURST_LEN);
   localparam int DQM_W  = DATA_W / 8;

   generate
      if (MAX_CL < 1) begin : g_bad_maxcl
         $error("MAX_CL must be at least 1");
      end
      if (RESET_CL < 1 || RESET_CL > MAX_CL) begin : g_bad_resetcl
         $error("RESET_CL must lie in 1..MAX_CL");
      end
      if (BURST_LEN < 1 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("BURST_LEN must be a power of two");
      end
      if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a multiple of 8");
      end
   endgenerate

   logic              issue;
   logic              pipe_busy;
   logic [CL_W-1:0]   cl_lat;
   logic              head_valid;
   logic [BEAT_W-1:0] head_beat;
   logic [TAG_W-1:0]  head_tag;

   assign dqm = {DQM_W{1'b0}};

   rd_cmd_issue #(
      .BANK_W(BANK_W), .COL_W(COL_W), .MAX_CL(MAX_CL),
      .RESET_CL(RESET_CL), .CL_W(CL_W)
   ) u_issue (
      .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl),
      .req_valid(req_valid), .req_bank(req_bank), .req_col(req_col),
      .pipe_busy(pipe_busy), .req_ready(req_ready), .issue(issue),
      .cl_lat(cl_lat), .cmd_read(cmd_read), .cmd_bank(cmd_bank),
      .cmd_col(cmd_col)
   );

   rd_track_pipe #(
      .TAG_W(TAG_W), .BEAT_W(BEAT_W), .BURST_LEN(BURST_LEN),
      .MAX_CL(MAX_CL), .CL_W(CL_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .issue(issue), .issue_tag(req_tag),
      .cl_lat(cl_lat), .head_valid(head_valid), .head_beat(head_beat),
      .head_tag(head_tag), .busy(pipe_busy)
   );

   rd_capture #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W), .HOLD_DATA(HOLD_DATA)
   ) u_cap (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
      .head_beat(head_beat), .head_tag(head_tag), .dq_in(dq_in),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag),
      .rd_beat(rd_beat)
   );

endmodule

// File: rtl/sdram_rd_pipe_chk.sv
module sdram_rd_pipe_chk #(
   parameter int CL_W   = 2,
   parameter int BEAT_W = 2,
   parameter int DQM_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              cmd_read,
   input logic [DQM_W-1:0]  dqm,
   input logic              rd_valid,
   input logic [BEAT_W-1:0] rd_beat,
   input logic [CL_W-1:0]   cl_lat,
   input logic              pipe_busy
);

   // R2
   dqm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dqm == '0);

   // R1
   read_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> cmd_read);

   // R1
   nop_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !cmd_read);

   // R7
   cl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_busy |=> $stable(cl_lat));

   // R3
   lat1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && cl_lat == CL_W'(1)) |-> ##2 (rd_valid && rd_beat == '0));

   // R3
   lat2_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && cl_lat == CL_W'(2)) |-> ##3 (rd_valid && rd_beat == '0));

   // R3
   lat3_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && cl_lat == CL_W'(3)) |-> ##4 (rd_valid && rd_beat == '0));

endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk #(
   .CL_W(CL_W), .BEAT_W(BEAT_W), .DQM_W(DQM_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .cmd_read(cmd_read), .dqm(dqm), .rd_valid(rd_valid), .rd_beat(rd_beat),
   .cl_lat(cl_lat), .pipe_busy(pipe_busy)
);

// File: tb/sim_sdram_rd_pipe.sv
module sim_sdram_rd_pipe;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_cl = 2'd3;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_bank = '0;
   logic [8:0]  req_col = '0;
   logic [3:0]  req_tag = '0;
   logic        cmd_read;
   logic [1:0]  cmd_bank;
   logic [8:0]  cmd_col;
   logic [3:0]  dqm;
   logic [31:0] dq_in = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [3:0]  rd_tag;
   logic [1:0]  rd_beat;

   always #5 clk = ~clk;

   sdram_rd_pipe u0 (
      .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .req_valid(req_valid),
      .req_ready(req_ready), .req_bank(req_bank), .req_col(req_col),
      .req_tag(req_tag), .cmd_read(cmd_read), .cmd_bank(cmd_bank),
      .cmd_col(cmd_col), .dqm(dqm), .dq_in(dq_in), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_tag(rd_tag), .rd_beat(rd_beat)
   );

   typedef struct {
      int          edge_n;
      logic [3:0]  tag;
      logic [1:0]  beat;
      logic [31:0] data;
      string       req;
   } exp_t;

   int          total = 0;
   int          bad = 0;
   int          ecount = 0;
   bit          done = 1'b0;
   int          tb_cl = 3;
   string       cur_req = "R3";
   exp_t        q[$];
   logic [10:0] acc_cmd[int];
   logic [31:0] dsched[int];

   function automatic logic [31:0] word_of(input logic [1:0] b, input logic [8:0] c);
      return {8'hC3, 3'b000, b, c, 10'h000};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) ecount++;

   // memory responder: driven purely from the command bus
   always @(negedge clk) begin
      if (rst_n && cmd_read) begin
         for (int b = 0; b < 4; b++)
            dsched[ecount + 1 + tb_cl + b] = word_of(cmd_bank, cmd_col + 9'(b));
      end
      dq_in = dsched.exists(ecount + 1) ? dsched[ecount + 1] : (32'hDEAD0000 ^ 32'(ecount));
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (acc_cmd.exists(ecount))
            chk(cmd_read && {cmd_bank, cmd_col} == acc_cmd[ecount], "R1", "read command",
                {cmd_read, cmd_bank, cmd_col}, {1'b1, acc_cmd[ecount]});
         else
            chk(!cmd_read, "R1", "nop command", cmd_read, 0);
         chk(dqm == 4'h0, "R2", "data mask", dqm, 0);
         while (q.size() > 0 && q[0].edge_n < ecount) begin
            chk(1'b0, q[0].req, "missing word", 0, q[0].data);
            void'(q.pop_front());
         end
         if (q.size() > 0 && q[0].edge_n == ecount) begin
            e = q.pop_front();
            chk(rd_valid && rd_data == e.data && rd_tag == e.tag && rd_beat == e.beat,
                e.req, "captured word", {rd_valid, rd_tag, rd_beat, rd_data},
                {1'b1, e.tag, e.beat, e.data});
         end else begin
            chk(!rd_valid, "R9", "stray strobe", rd_valid, 0);
         end
      end
   end

   task automatic issue(input logic [1:0] bank, input logic [8:0] col,
                        input logic [3:0] tag, input int spacing);
      int w = 0;
      int k;
      int s;
      @(negedge clk);
      req_bank  = bank;
      req_col   = col;
      req_tag   = tag;
      req_valid = 1'b1;
      while (!req_ready && w < 50) begin
         @(negedge clk);
         w++;
      end
      k = ecount + 1;
      s = k + 1 + tb_cl;
      while (q.size() > 0 && q[$].edge_n >= s)
         void'(q.pop_back());
      acc_cmd[k] = {bank, col};
      for (int b = 0; b < 4; b++) begin
         exp_t e;
         e.edge_n = s + b;
         e.tag    = tag;
         e.beat   = 2'(b);
         e.data   = word_of(bank, col + 9'(b));
         e.req    = cur_req;
         q.push_back(e);
      end
      repeat (spacing - 1) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   task automatic set_cl(input logic [1:0] v, input int eff);
      int w = 0;
      idle(1);
      @(negedge clk);
      cfg_cl = v;
      tb_cl  = eff;
      #1;
      while (!req_ready && w < 100) begin
         @(negedge clk);
         w++;
      end
      chk(req_ready, "R7", "ready after latency load", req_ready, 1);
   endtask

   task automatic run_patterns(input int base);
      cur_req = "R3";
      issue(2'd0, 9'd5, 4'(base), 8);
      cur_req = "R5";
      issue(2'd1, 9'd10, 4'(base + 1), 4);
      issue(2'd1, 9'd14, 4'(base + 2), 4);
      issue(2'd2, 9'd0, 4'(base + 3), 4);
      issue(2'd3, 9'd510, 4'(base + 4), 6);
      cur_req = "R6";
      issue(2'd0, 9'd7, 4'(base + 5), 1);
      issue(2'd0, 9'd9, 4'(base + 6), 2);
      issue(2'd1, 9'd3, 4'(base + 7), 3);
      issue(2'd2, 9'd100, 4'(base + 8), 5);
      cur_req = "R4";
      issue(2'd3, 9'd33, 4'(base + 9), 5);
      issue(2'd3, 9'd34, 4'(base + 10), 5);
      idle(8);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8 reset state
      chk(!cmd_read, "R8", "cmd after reset", cmd_read, 0);
      chk(!rd_valid, "R8", "strobe after reset", rd_valid, 0);
      chk(req_ready, "R8", "ready with default latency", req_ready, 1);

      tb_cl = 3;
      run_patterns(0);
      set_cl(2'd1, 1);
      run_patterns(3);
      set_cl(2'd2, 2);
      run_patterns(6);

      // R7 latency change attempted while reads drain
      set_cl(2'd3, 3);
      cur_req = "R7";
      issue(2'd1, 9'd200, 4'd12, 1);
      idle(1);
      @(negedge clk);
      cfg_cl = 2'd2;
      tb_cl  = 2;
      #1;
      chk(!req_ready, "R7", "ready held while busy", req_ready, 0);
      begin
         int w = 0;
         while (!req_ready && w < 100) begin
            @(negedge clk);
            w++;
         end
         chk(w >= 3, "R7", "latency load waited for drain", w, 3);
      end
      issue(2'd2, 9'd201, 4'd13, 6);

      // R7 setting 0 selects latency 1
      set_cl(2'd0, 1);
      cur_req = "R7";
      issue(2'd0, 9'd300, 4'd14, 2);
      issue(2'd3, 9'd301, 4'd15, 6);
      idle(12);
      chk(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R9 actual=%0d expected=%0d", ecount, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule